// File: doc/BRIEF.md
# Two-Wire Slave Memory Controller with Write Gate

This block is the slave side of a two-wire serial bus (I2C style) in front of a 128-byte memory. It watches already-synchronized clock and data lines for start and stop conditions. It accepts a device select byte and acknowledges the bytes it takes in. It serves current-address, random and sequential reads, and byte or page writes.

Write data is gathered in an 8-entry page buffer. The buffer is only committed when a write transaction ends in a stop condition while the external write gate is high. A commit starts a self-timed programming interval, counted in clock cycles. During that interval the block ignores the bus entirely. When the count runs out, the buffered bytes are written into the memory through the memory port in one burst. A mode-enable input parks the block in a passive state, in which it never drives the bus.

The memory sits outside the block. It has a single address, a write strobe and a read data bus, and read data is returned one clock after the address. The data line output is a pull-low request, and the pad logic outside the block turns it into an open-drain driver.

Top module: `i2cm_eeprom_slave`

## Requirements
- R1: After reset the block does not pull the data line. A start condition is a high-to-low data transition while the clock is high, and a stop condition is a low-to-high data transition while the clock is high.
- R2: The select byte is received most significant bit first. The block acknowledges it (pulls data low during the 9th clock) only when its upper nibble is 1010. Bits 3..1 are ignored, and bit 0 = 1 requests a read. Any other upper nibble gets no acknowledge.
- R3: A write is start, select with bit 0 = 0, one address byte (low 7 bits used), data bytes, then stop. With the write gate high, each data byte lands at its address in the memory.
- R4: Successive write data bytes advance only the low 3 address bits, so they wrap inside the 8-byte page selected by address bits 6..3. Only the page locations that received a byte are written.
- R5: If the write gate is low at the stop, nothing is written and the block answers the bus again at once.
- R6: A committed write starts a programming interval of PROG_CYCLES clocks. During it the block never pulls the data line and ignores start conditions, and memory is only written after the interval ends.
- R7: A random read (write select, address byte, repeated start, read select) returns the byte at that address.
- R8: A current-address read returns the byte after the last one read.
- R9: A sequential read continues while the master acknowledges each byte, and the address wraps from 127 to 0.
- R10: A master non-acknowledge after a read byte ends the read. The block then leaves the data line released for any further clocks until the next start.
- R11: While mode enable is low (and no programming interval is running), the block does not respond to the bus.
- R12: A stop after a write transaction that carried no data byte starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired level) |
| mode_en_i | input | 1 | Enables bus responses when high |
| wr_gate_i | input | 1 | Allows a write commit when high at the stop |
| sda_pull_o | output | 1 | Request to pull the data line low |
| mem_addr_o | output | AW | Memory address (read or commit) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data, one clock after address |

## Verification
The assertions assume that the bus clock and data are clean, already synchronized, and held for several core clocks per phase. They also assume that data changes only while the bus clock is low, except for deliberate start and stop conditions. Under those conditions a rising pull request can only appear with the clock low. The stimulus respects this by driving every bus phase on the falling core clock edge for a fixed quarter-bit of five cycles. Data is changed only in the low phase, and start and stop are formed only with the clock held high. The bench memory model answers reads with the one-cycle latency that the block expects.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_BUSY
  } st_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_cond_det.sv
module i2cm_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
  parameter int PAGE = 8,
  parameter int W    = 8,
  localparam int IW  = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  logic [W-1:0]    data_q [PAGE];
  logic [PAGE-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_data;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/i2cm_prog_timer.sv
module i2cm_prog_timer #(
  parameter int CYCLES = 1000,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt_q <= CW'(CYCLES - 1);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2cm_eeprom_slave.sv
module i2cm_eeprom_slave
  import i2cm_pkg::*;
#(
  parameter int AW          = 7,
  parameter int PAGE        = 8,
  parameter int PROG_CYCLES = 1000,
  localparam int PW         = $clog2(PAGE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              mode_en_i,
  input  logic              wr_gate_i,
  output logic              sda_pull_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  st_e              st_q, pend_q;
  logic [3:0]       bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-2:0] tx_q;
  logic             pull_q;
  logic [AW-1:0]    ptr_q;
  logic [AW-PW-1:0] page_q;
  logic             commit_q;
  logic [PW-1:0]    cidx_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy_w, byte_end, buf_wr, buf_clr, go_busy, t_done;
  logic [BYTE_W-1:0] buf_rd_data;
  logic buf_rd_valid, buf_any;

  i2cm_cond_det u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign busy_w   = (st_q == ST_BUSY);
  assign byte_end = mode_en_i && !busy_w && !start_det && !stop_det &&
                    scl_fall && (bit_q == 4'd8) &&
                    (st_q == ST_DEV || st_q == ST_ADDR || st_q == ST_WR);
  assign buf_wr   = byte_end && (st_q == ST_WR);
  assign buf_clr  = start_det && !busy_w && mode_en_i;
  assign go_busy  = mode_en_i && !busy_w && !start_det && stop_det &&
                    (st_q == ST_WR) && buf_any && wr_gate_i;

  i2cm_page_buf #(.PAGE(PAGE), .W(BYTE_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(ptr_q[PW-1:0]), .wr_data(sh_q),
    .rd_idx(cidx_q), .rd_data(buf_rd_data),
    .rd_valid(buf_rd_valid), .any_valid(buf_any)
  );

  i2cm_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(go_busy), .done(t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pend_q   <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      pull_q   <= 1'b0;
      ptr_q    <= '0;
      page_q   <= '0;
      commit_q <= 1'b0;
      cidx_q   <= '0;
    end else if (busy_w) begin
      pull_q <= 1'b0;
      if (t_done) begin
        commit_q <= 1'b1;
        cidx_q   <= '0;
      end else if (commit_q) begin
        if (cidx_q == PW'(PAGE - 1)) begin
          commit_q <= 1'b0;
          st_q     <= ST_IDLE;
        end
        cidx_q <= cidx_q + PW'(1);
      end
    end else if (!mode_en_i) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      bit_q  <= '0;
    end else if (start_det) begin
      st_q   <= ST_DEV;
      bit_q  <= '0;
      pull_q <= 1'b0;
    end else if (stop_det) begin
      pull_q <= 1'b0;
      bit_q  <= '0;
      st_q   <= go_busy ? ST_BUSY : ST_IDLE;
    end else begin
      case (st_q)
        ST_DEV, ST_ADDR, ST_WR: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            bit_q <= bit_q + 4'd1;
          end else if (scl_rise && bit_q == 4'd8) begin
            bit_q <= 4'd9;
          end else if (byte_end) begin
            if (st_q == ST_DEV) begin
              if (sh_q[7:4] == DEV_CODE) begin
                pull_q <= 1'b1;
                pend_q <= sh_q[0] ? ST_RD : ST_ADDR;
              end else begin
                st_q  <= ST_IDLE;
                bit_q <= '0;
              end
            end else if (st_q == ST_ADDR) begin
              pull_q <= 1'b1;
              ptr_q  <= sh_q[AW-1:0];
              page_q <= sh_q[AW-1:PW];
              pend_q <= ST_WR;
            end else begin
              pull_q          <= 1'b1;
              ptr_q[PW-1:0]   <= ptr_q[PW-1:0] + PW'(1);
              pend_q          <= ST_WR;
            end
          end else if (scl_fall && bit_q == 4'd9) begin
            bit_q  <= '0;
            st_q   <= pend_q;
            pull_q <= 1'b0;
            if (pend_q == ST_RD) begin
              tx_q   <= mem_rdata_i[BYTE_W-2:0];
              pull_q <= ~mem_rdata_i[BYTE_W-1];
            end
          end
        end
        ST_RD: begin
          if (scl_rise && bit_q < 4'd8) begin
            bit_q <= bit_q + 4'd1;
          end else if (scl_rise && bit_q == 4'd8) begin
            if (sda_i) begin
              st_q  <= ST_IDLE;
              bit_q <= '0;
            end else begin
              bit_q <= 4'd9;
            end
          end else if (scl_fall && bit_q >= 4'd1 && bit_q <= 4'd7) begin
            tx_q   <= {tx_q[BYTE_W-3:0], 1'b0};
            pull_q <= ~tx_q[BYTE_W-2];
          end else if (scl_fall && bit_q == 4'd8) begin
            pull_q <= 1'b0;
            ptr_q  <= ptr_q + AW'(1);
          end else if (scl_fall && bit_q == 4'd9) begin
            tx_q   <= mem_rdata_i[BYTE_W-2:0];
            pull_q <= ~mem_rdata_i[BYTE_W-1];
            bit_q  <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o  = pull_q;
  assign mem_addr_o  = commit_q ? {page_q, cidx_q} : ptr_q;
  assign mem_we_o    = commit_q & buf_rd_valid;
  assign mem_wdata_o = buf_rd_data;
endmodule

// File: rtl/i2cm_eeprom_slave_chk.sv
module i2cm_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic mode_en_i,
  input logic wr_gate_i,
  input logic sda_pull_o,
  input logic mem_we_o,
  input logic busy
);
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_i); // R2

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy); // R3

  AST_GATE_AT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_gate_i)); // R5

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull_o); // R6

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mode_en_i && !busy) |=> !sda_pull_o); // R11
endmodule

bind i2cm_eeprom_slave i2cm_eeprom_slave_chk chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .mode_en_i(mode_en_i),
  .wr_gate_i(wr_gate_i), .sda_pull_o(sda_pull_o), .mem_we_o(mem_we_o),
  .busy(busy_w)
);

// File: tb/i2cm_eeprom_slave_tb_top.sv
module i2cm_eeprom_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int PROG       = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic scl = 1'b1, sda_m = 1'b1, mode_en = 1'b1, wr_gate = 1'b1;
  logic sda_pull, mwe;
  logic [6:0] maddr;
  logic [7:0] mwd, mrd;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] mem [128];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'h5A;
    end else if (mwe) begin
      mem[maddr] <= mwd;
    end
    mrd <= mem[maddr];
  end

  i2cm_eeprom_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .mode_en_i(mode_en), .wr_gate_i(wr_gate), .sda_pull_o(sda_pull),
    .mem_addr_o(maddr), .mem_wdata_o(mwd), .mem_we_o(mwe),
    .mem_rdata_i(mrd)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~master_ack);
  endtask

  task automatic set_addr(input logic [6:0] a);
    logic ak;
    i2c_start();
    send_byte(8'hA0, ak); chk("R7 select ack", int'(ak), 1);
    send_byte({1'b0, a}, ak); chk("R7 address ack", int'(ak), 1);
  endtask

  task automatic t_reset();
    chk("R1 no pull after reset", int'(sda_pull), 0);
    chk("R1 bus idle high", int'(sda_bus), 1);
  endtask

  task automatic t_bad_select();
    logic ak;
    i2c_start();
    send_byte(8'h9E, ak); chk("R2 wrong code nack", int'(ak), 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hAE, ak); chk("R2 don't-care bits acked", int'(ak), 1);
    i2c_stop();
  endtask

  task automatic t_byte_write();
    logic ak;
    i2c_start();
    send_byte(8'hA0, ak); chk("R3 select ack", int'(ak), 1);
    send_byte(8'h10, ak); chk("R3 address ack", int'(ak), 1);
    send_byte(8'hC3, ak); chk("R3 data ack", int'(ak), 1);
    i2c_stop();
    chk("R6 no write before interval", int'(mem[7'h10]), int'(init_val(16)));
    i2c_start();
    send_byte(8'hA1, ak); chk("R6 busy ignores select", int'(ak), 0);
    chk("R6 busy never pulls", int'(sda_pull), 0);
    i2c_stop();
    repeat (PROG + 40) @(negedge clk);
    chk("R3 byte written", int'(mem[7'h10]), 8'hC3);
    chk("R3 neighbour untouched", int'(mem[7'h11]), int'(init_val(17)));
  endtask

  task automatic t_page_write();
    logic ak;
    i2c_start();
    send_byte(8'hA0, ak);
    send_byte(8'h1E, ak);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hA0 + 8'(i), ak);
      chk("R4 page data ack", int'(ak), 1);
    end
    i2c_stop();
    repeat (PROG + 40) @(negedge clk);
    chk("R4 offset 6", int'(mem[7'h1E]), 8'hA0);
    chk("R4 offset 7", int'(mem[7'h1F]), 8'hA1);
    chk("R4 wrap to offset 0", int'(mem[7'h18]), 8'hA2);
    chk("R4 wrap to offset 1", int'(mem[7'h19]), 8'hA3);
    chk("R4 unsent slot kept", int'(mem[7'h1A]), int'(init_val(8'h1A)));
    chk("R4 next page kept", int'(mem[7'h20]), int'(init_val(8'h20)));
  endtask

  task automatic t_gate_low();
    logic ak;
    logic [7:0] v;
    wr_gate = 1'b0;
    i2c_start();
    send_byte(8'hA0, ak);
    send_byte(8'h28, ak);
    send_byte(8'h77, ak);
    i2c_stop();
    wr_gate = 1'b1;
    i2c_start();
    send_byte(8'hA1, ak); chk("R5 responds at once", int'(ak), 1);
    recv_byte(1'b0, v);
    i2c_stop();
    repeat (PROG + 40) @(negedge clk);
    chk("R5 gated write dropped", int'(mem[7'h28]), int'(init_val(8'h28)));
  endtask

  task automatic t_random_read();
    logic ak;
    logic [7:0] v;
    set_addr(7'h10);
    i2c_start();
    send_byte(8'hA1, ak); chk("R7 read select ack", int'(ak), 1);
    recv_byte(1'b0, v);
    i2c_stop();
    chk("R7 random read data", int'(v), 8'hC3);
  endtask

  task automatic t_current_read();
    logic ak;
    logic [7:0] v;
    i2c_start();
    send_byte(8'hA1, ak);
    recv_byte(1'b0, v);
    i2c_stop();
    chk("R8 current address data", int'(v), int'(init_val(17)));
  endtask

  task automatic t_seq_read();
    logic ak, b;
    logic [7:0] v0, v1, v2;
    set_addr(7'h7E);
    i2c_start();
    send_byte(8'hA1, ak);
    recv_byte(1'b1, v0);
    recv_byte(1'b1, v1);
    recv_byte(1'b0, v2);
    chk("R9 seq byte 0", int'(v0), int'(init_val(8'h7E)));
    chk("R9 seq byte 1", int'(v1), int'(init_val(8'h7F)));
    chk("R9 wrap to 0", int'(v2), int'(init_val(0)));
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      chk("R10 released after nack", int'(b), 1);
    end
    i2c_stop();
  endtask

  task automatic t_mode_off();
    logic ak;
    mode_en = 1'b0;
    i2c_start();
    send_byte(8'hA1, ak); chk("R11 no ack when disabled", int'(ak), 0);
    i2c_stop();
    mode_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_empty_write();
    logic ak;
    logic [7:0] v;
    set_addr(7'h30);
    i2c_stop();
    i2c_start();
    send_byte(8'hA1, ak); chk("R12 no interval after empty write", int'(ak), 1);
    recv_byte(1'b0, v);
    i2c_stop();
    chk("R12 read at set address", int'(v), int'(init_val(8'h30)));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_select();
    t_byte_write();
    t_page_write();
    t_gate_low();
    t_random_read();
    t_current_read();
    t_seq_read();
    t_mode_off();
    t_empty_write();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule